// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial EEPROM, built for a chip that has a system clock. It samples the clock line and the data line with that clock and finds start and stop conditions in the sampled values. It takes in a device byte and, for writes, a word address, then either stores incoming bytes or shifts stored bytes out. It never drives the data line high. Its only output is an enable that pulls the line low, and the pad or the bench supplies the pull-up and the wired-AND.

A parameter sets the storage size to 256, 512, 1024 or 2048 bytes. The size decides how many of the three selector bits in the device byte are compared with the hard-wired pins, and how many become the top bits of the word address. A write is held in a page buffer and is not written to the array at once. A stop starts a busy window whose length is a parameter. The buffered bytes are written to the array only when that window has run out. The slave does not answer its address while the window is open. A write-protect input lets a whole write session be accepted on the bus but stored nowhere.

Top module: `eep_slave`

## Requirements
- R1: After reset the slave does not pull the data line low, and the line reads high while no host drives it.
- R2: The slave acknowledges a device byte only when its top nibble is 4'b1010 and the compared selector bits (bit 3 against pin 2, bit 2 against pin 1, bit 1 against pin 0) match the pins. At 1024 bytes only bit 3 is compared. Bit 0 is the direction: 1 for read, 0 for write. A non-matching byte gets no acknowledge.
- R3: The selector bits that are not compared are page bits. At 1024 bytes, device byte bits 2:1 become word-address bits 9:8, and the word-address byte supplies bits 7:0.
- R4: A byte write, made of device byte, address and one data byte, acknowledges every byte. A later random read of that address returns the data.
- R5: In a page write the low four address bits (three at 256 bytes) advance after each data byte and wrap inside the same page. Extra bytes overwrite the start of the page. Bytes outside the page stay unchanged.
- R6: A stop after at least one stored data byte opens a busy window of BUSY_CYCLES clocks plus one clock per page slot. During the window no device byte is acknowledged. The bytes are written to the array only at its end.
- R7: While the write-protect input is high, data bytes are still acknowledged but discarded. The array keeps its old contents and no busy window starts.
- R8: A sequential read advances through the whole array, and the address wraps from the last byte to byte 0.
- R9: A current-address read returns the byte after the last one accessed.
- R10: A start anywhere, including in the middle of a byte, releases the line, discards buffered write data and restarts device-byte reception.
- R11: After the host gives no acknowledge on a read byte, the slave releases the line before the stop.
- R12: The slave changes its drive only while the clock line is low, and keeps it constant through every clock-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Two-wire clock line, asynchronous |
| sda_i | input | 1 | Two-wire data line as seen at the pad, asynchronous |
| dev_pins_i | input | 3 | Hard-wired selector pins (bit 2, bit 1, bit 0) |
| wp_i | input | 1 | Write protect: 1 blocks all array writes |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (open-drain enable) |

## Verification
A wrong bit counter or a wrong phase shows at the ports as an acknowledge that lands on the wrong clock. The host sees that on its next ninth-clock sample, within one byte time. A wrong word-address register or page-wrap logic stays hidden on the bus until the next read. So every write scenario is followed by a readback, and the page test reads across the page edge. A wrong busy flag or page-buffer valid mask shows as an acknowledge while it should be refused, or as a stale readback. The bench therefore polls right after each stop and again after the window has run out.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } phase_t;

  // Number of selector bits that are compared with pins for a given size.
  function automatic int pins_compared(input int bytes);
    if (bytes <= 256)       return 3;
    else if (bytes <= 512)  return 2;
    else if (bytes <= 1024) return 1;
    else                    return 0;
  endfunction

  function automatic int page_size(input int bytes);
    return (bytes <= 256) ? 8 : 16;
  endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_commit.sv
module eep_commit #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 200,
  localparam int PG_W       = $clog2(PAGE_BYTES),
  localparam int HI_W       = ADDR_W - PG_W,
  localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_en,
  input  logic [PG_W-1:0]   store_idx,
  input  logic [HI_W-1:0]   store_page,
  input  logic [7:0]        store_data,
  input  logic              discard,
  input  logic              launch,
  output logic              busy_o,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [HI_W-1:0]       page_q;
  logic                  wait_q, cmt_q;
  logic [CW-1:0]         cnt;
  logic [PG_W-1:0]       cidx;

  assign busy_o = wait_q | cmt_q;

  always_ff @(posedge clk) begin
    if (store_en && !busy_o) pbuf[store_idx] <= store_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      page_q <= '0;
      wait_q <= 1'b0;
      cmt_q  <= 1'b0;
      cnt    <= '0;
      cidx   <= '0;
    end else if (wait_q) begin
      if (cnt == '0) begin
        wait_q <= 1'b0;
        cmt_q  <= 1'b1;
        cidx   <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end else if (cmt_q) begin
      cidx <= cidx + PG_W'(1);
      if (cidx == PG_W'(PAGE_BYTES - 1)) begin
        cmt_q <= 1'b0;
        vld   <= '0;
      end
    end else if (discard) begin
      vld <= '0;
    end else if (launch) begin
      if (|vld) begin
        wait_q <= 1'b1;
        cnt    <= CW'(BUSY_CYCLES - 1);
      end
    end else if (store_en) begin
      vld[store_idx] <= 1'b1;
      page_q         <= store_page;
    end
  end

  assign mem_we    = cmt_q & vld[cidx];
  assign mem_waddr = {page_q, cidx};
  assign mem_wdata = pbuf[cidx];
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int MEM_BYTES   = 1024,
  parameter int BUSY_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i,
  output logic       sda_drive_low_o
);
  import eep_pkg::*;

  localparam int ADDR_W     = $clog2(MEM_BYTES);
  localparam int PAGE_BYTES = page_size(MEM_BYTES);
  localparam int PG_W       = $clog2(PAGE_BYTES);
  localparam int NCMP       = pins_compared(MEM_BYTES);
  localparam int NPG        = 3 - NCMP;
  localparam int PGQ_W      = (NPG > 0) ? NPG : 1;
  localparam logic [2:0] CMP_MASK = 3'(~(3'b111 >> NCMP));

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_ev), .stop_o(stop_ev)
  );

  phase_t            st;
  logic [3:0]        cnt;
  logic [7:0]        shreg, tx;
  logic              drv, host_ack;
  logic [ADDR_W-1:0] word_addr, addr_load;
  logic [PGQ_W-1:0]  pg_q, pg_dev;
  logic [7:0]        rd_q;
  logic              busy, dev_ok, store_en;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  generate
    if (NPG > 0) begin : g_pg
      assign pg_dev    = shreg[NPG:1];
      assign addr_load = {pg_q, shreg};
    end else begin : g_nopg
      assign pg_dev    = 1'b0;
      assign addr_load = shreg;
    end
  endgenerate

  assign dev_ok = (shreg[7:4] == 4'b1010) &&
                  (((shreg[3:1] ^ dev_pins_i) & CMP_MASK) == 3'b000) && !busy;

  assign store_en = (st == ST_WDATA) && scl_fall && (cnt == 4'd8) &&
                    !start_ev && !stop_ev && !wp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      drv       <= 1'b0;
      host_ack  <= 1'b0;
      word_addr <= '0;
      pg_q      <= '0;
    end else if (start_ev) begin
      st  <= ST_DEV;
      cnt <= '0;
      drv <= 1'b0;
    end else if (stop_ev) begin
      st  <= ST_IDLE;
      drv <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (st == ST_RDATA) begin
          if (cnt == 4'd8) host_ack <= ~sda_s;
        end else if (cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_s};
        end
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd9) begin
          cnt <= '0;
          drv <= 1'b0;
          if (st == ST_RDATA) begin
            if (host_ack) begin
              tx        <= rd_q;
              drv       <= ~rd_q[7];
              word_addr <= word_addr + ADDR_W'(1);
            end else begin
              st <= ST_IDLE;
            end
          end
        end else if (st == ST_RDATA) begin
          if (cnt == 4'd8)      drv <= 1'b0;
          else if (cnt != 4'd0) drv <= ~tx[3'd7 - cnt[2:0]];
        end else if (cnt == 4'd8) begin
          unique case (st)
            ST_DEV: begin
              if (dev_ok) begin
                drv      <= 1'b1;
                pg_q     <= pg_dev;
                host_ack <= 1'b1;
                st       <= shreg[0] ? ST_RDATA : ST_WADDR;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_WADDR: begin
              drv       <= 1'b1;
              word_addr <= addr_load;
              st        <= ST_WDATA;
            end
            ST_WDATA: begin
              drv       <= 1'b1;
              word_addr <= {word_addr[ADDR_W-1:PG_W], word_addr[PG_W-1:0] + PG_W'(1)};
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign sda_drive_low_o = drv;

  eep_commit #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_commit (
    .clk(clk), .rst(rst),
    .store_en(store_en),
    .store_idx(word_addr[PG_W-1:0]),
    .store_page(word_addr[ADDR_W-1:PG_W]),
    .store_data(shreg),
    .discard(start_ev),
    .launch(stop_ev),
    .busy_o(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eep_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(word_addr), .rdata(rd_q)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            drv,
  input logic            busy,
  input logic            start_ev,
  input logic            stop_ev,
  input eep_pkg::phase_t st
);
  import eep_pkg::*;

  AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !drv);  // R6

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));  // R6

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (st == ST_DEV && !drv));  // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !drv);  // R11

  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(drv) |-> !scl_s);  // R12
endmodule

bind eep_slave eep_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .drv(sda_drive_low_o),
  .busy(busy), .start_ev(start_ev), .stop_ev(stop_ev), .st(st)
);

// File: tb/eep_slave_tb.sv
module eep_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 200;
  localparam int SETTLE     = BUSY + 16 + 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic wp = 1'b0;
  logic drv;
  wire  sda_line = sda_host & ~drv;

  int total = 0;
  int bad = 0;
  int glitch = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_slave #(.MEM_BYTES(1024), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .dev_pins_i(3'b100), .wp_i(wp), .sda_drive_low_o(drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    logic d0;
    tick(4); sda_host = b;
    tick(4); scl = 1'b1;
    tick(1); d0 = drv;
    tick(3); r = sda_line;
    tick(3); if (drv !== d0) glitch++;
    tick(1); scl = 1'b0;
  endtask

  task automatic start_c();
    sda_host = 1'b1; tick(4);
    scl = 1'b1;      tick(4);
    sda_host = 1'b0; tick(4);
    scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(4); sda_host = 1'b0;
    tick(4); scl = 1'b1;
    tick(4); sda_host = 1'b1;
    tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      b[i] = r;
    end
    bit_xfer(~give_ack, r);
  endtask

  function automatic logic [7:0] devb(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b1, a[9:8], rd};
  endfunction

  task automatic wr_seq(input logic [9:0] a, input int n, input logic [7:0] seed, output logic ok);
    logic ack;
    ok = 1'b1;
    start_c();
    send_byte(devb(a, 1'b0), ack); ok &= ack;
    send_byte(a[7:0], ack);        ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i), ack); ok &= ack;
    end
    stop_c();
  endtask

  task automatic rd_rand(input logic [9:0] a, input int n, output logic ok);
    logic ack;
    ok = 1'b1;
    start_c();
    send_byte(devb(a, 1'b0), ack); ok &= ack;
    send_byte(a[7:0], ack);        ok &= ack;
    start_c();
    send_byte(devb(a, 1'b1), ack); ok &= ack;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    stop_c();
  endtask

  task automatic t_reset();
    chk("R1 drive after reset", drv, 1'b0);
    chk("R1 line high", sda_line, 1'b1);
  endtask

  task automatic t_byte_write();
    logic ok;
    wr_seq(10'h123, 1, 8'h5A, ok); chk("R4 write acks", ok, 1'b1); tick(SETTLE);
    wr_seq(10'h124, 1, 8'h6B, ok); tick(SETTLE);
    rd_rand(10'h123, 1, ok);
    chk("R4 read acks", ok, 1'b1);
    chk("R4 readback", rbuf[0], 8'h5A);
  endtask

  task automatic t_page_bits();
    logic ok;
    wr_seq(10'h245, 1, 8'h11, ok); tick(SETTLE);
    wr_seq(10'h045, 1, 8'h22, ok); tick(SETTLE);
    rd_rand(10'h245, 1, ok); chk("R3 page 2", rbuf[0], 8'h11);
    rd_rand(10'h045, 1, ok); chk("R3 page 0", rbuf[0], 8'h22);
  endtask

  task automatic t_mismatch();
    logic ack;
    start_c(); send_byte(8'b1011_1000, ack); stop_c();
    chk("R2 wrong prefix nack", ack, 1'b0);
    start_c(); send_byte(8'b1010_0000, ack); stop_c();
    chk("R2 pin mismatch nack", ack, 1'b0);
    start_c(); send_byte(8'b1010_1000, ack); stop_c();
    chk("R2 match ack", ack, 1'b1);
  endtask

  task automatic t_rollover();
    logic ok;
    wr_seq(10'h110, 1, 8'h77, ok); tick(SETTLE);
    wr_seq(10'h10E, 18, 8'h40, ok); tick(SETTLE);
    chk("R5 page acks", ok, 1'b1);
    rd_rand(10'h10D, 4, ok);
    chk("R5 idx D", rbuf[0], 8'h4F);
    chk("R5 idx E wrapped", rbuf[1], 8'h50);
    chk("R5 idx F wrapped", rbuf[2], 8'h51);
    chk("R5 next page kept", rbuf[3], 8'h77);
    rd_rand(10'h100, 1, ok);
    chk("R5 idx 0", rbuf[0], 8'h42);
  endtask

  task automatic t_busy();
    logic ok, ack;
    wr_seq(10'h300, 1, 8'h99, ok);
    start_c(); send_byte(devb(10'h300, 1'b0), ack); stop_c();
    chk("R6 nack while busy", ack, 1'b0);
    tick(SETTLE);
    start_c(); send_byte(devb(10'h300, 1'b0), ack); stop_c();
    chk("R6 ack after window", ack, 1'b1);
    rd_rand(10'h300, 1, ok);
    chk("R6 committed", rbuf[0], 8'h99);
  endtask

  task automatic t_wp();
    logic ok, ack;
    wp = 1'b1;
    wr_seq(10'h300, 3, 8'h01, ok);
    chk("R7 acks under protect", ok, 1'b1);
    start_c(); send_byte(devb(10'h300, 1'b0), ack); stop_c();
    chk("R7 no busy window", ack, 1'b1);
    wp = 1'b0;
    rd_rand(10'h300, 1, ok);
    chk("R7 array unchanged", rbuf[0], 8'h99);
  endtask

  task automatic t_seq_wrap();
    logic ok;
    wr_seq(10'h3FF, 1, 8'hEE, ok); tick(SETTLE);
    wr_seq(10'h000, 1, 8'h0D, ok); tick(SETTLE);
    rd_rand(10'h3FF, 2, ok);
    chk("R8 last byte", rbuf[0], 8'hEE);
    chk("R8 wrap to zero", rbuf[1], 8'h0D);
  endtask

  task automatic t_current();
    logic ok, ack;
    logic [7:0] b;
    rd_rand(10'h123, 1, ok);
    start_c();
    send_byte(devb(10'h000, 1'b1), ack);
    recv_byte(1'b0, b);
    tick(6);
    chk("R11 released after nack", drv, 1'b0);
    stop_c();
    chk("R9 current address", b, 8'h6B);
  endtask

  task automatic t_abort();
    logic ok, ack, r;
    wr_seq(10'h050, 1, 8'h31, ok); tick(SETTLE);
    start_c();
    send_byte(devb(10'h050, 1'b0), ack);
    send_byte(8'h50, ack);
    send_byte(8'hC4, ack);
    start_c();
    send_byte(devb(10'h050, 1'b0), ack);
    stop_c();
    chk("R10 no busy after restart", ack, 1'b1);
    start_c();
    for (int i = 0; i < 4; i++) bit_xfer(i[0], r);
    rd_rand(10'h050, 1, ok);
    chk("R10 mid-byte restart acks", ok, 1'b1);
    chk("R10 data discarded", rbuf[0], 8'h31);
  endtask

  initial begin
    tick(5); rst = 1'b0; tick(5);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page_bits();
    t_rollover();
    t_busy();
    t_wp();
    t_seq_wrap();
    t_current();
    t_abort();
    chk("R12 drive stable while clock high", glitch, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule